// File: doc/BRIEF.md
# Elapsed-Seconds Clock with Watchdog

This block keeps an elapsed-time count in whole seconds and watches over the software. It runs from a low-frequency tick: a clock-enable input that pulses at 32.768 kHz, one system clock wide. A prescaler divides the tick down to one strobe per second. The strobe advances a seconds counter that stops at its top value instead of wrapping. With the default 24-bit width this spans about 194 days.

Software reads the count as three byte registers over a small address-only register bus. A read of the low byte takes a snapshot of the whole count. Later reads of the middle and high bytes return that same snapshot, so the three bytes always agree.

A watchdog counts the same tick. If software does not write the watchdog kick address within about two seconds, the watchdog raises a one-cycle system-reset request. A power-down input stops register access and freezes the watchdog, while the seconds count keeps running. A configuration input turns the watchdog off.

Top module: `rtc_wdog_top`

## Requirements
- R1: The prescaler produces one seconds strobe every PRESCALE pulses of `tick_en` (32768 by default), and the seconds count advances only on that strobe.
- R2: After reset the seconds count is zero, and it rises by exactly one on each seconds strobe.
- R3: Once the seconds count is all ones (CNT_W bits wide), it stays all ones on later strobes. It never wraps.
- R4: A read returns its data in `bus_rdata` one cycle after the access. Address 0 returns count bits 7:0 and at the same time captures the whole count into a snapshot. Address 1 returns bits 15:8 of the snapshot and address 2 returns bits 23:16, with the count zero-extended to 24 bits.
- R5: If no kick arrives, the watchdog raises `sys_rst_req` for exactly one cycle after WDOG_TICKS pulses of `tick_en` (65536 by default). The pulse restarts its count, so the next pulse follows after another WDOG_TICKS pulses.
- R6: A write to address 3 clears both the prescaler and the seconds count. The snapshot keeps its value.
- R7: A write to address 4 (kick) clears the watchdog count. When a kick falls in the same cycle as the expiring tick, the kick wins and no pulse is raised.
- R8: While `wdog_dis` is high the watchdog count is held at zero and no pulse is raised. After release a full WDOG_TICKS pulses are needed to expire.
- R9: While `pwr_down` is high the seconds count keeps advancing and the watchdog count is frozen.
- R10: While `pwr_down` is high, reads return zero and leave the snapshot unchanged, and writes (clear and kick) have no effect.
- R11: A low `rst_n` clears the prescaler, the seconds count, the snapshot, the read data and the watchdog count.
- R12: A read of any address other than 0, 1 or 2 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_en | input | 1 | 32.768 kHz tick, one clock wide |
| pwr_down | input | 1 | Power-down: blocks bus access and freezes the watchdog |
| wdog_dis | input | 1 | Watchdog disable configuration bit |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write (address-only strobe), 0 = read |
| bus_addr | input | 3 | Register address |
| bus_rdata | output | 8 | Read data, valid one cycle after a read access |
| sys_rst_req | output | 1 | One-cycle system-reset request from the watchdog |

## Verification
The watchdog's expiring tick and a software kick can land in the same clock cycle. The bench provokes this by bringing the watchdog count to one below its limit and then driving `tick_en` and a kick write to address 4 in the same cycle. It expects no reset pulse. It then expects the next pulse only after a full fresh window of ticks, which shows that the kick both won and restarted the count.

// File: rtl/rtc_pkg.sv
// Shared register addresses and decoded bus strobes for the seconds clock.
// Assumes a 3-bit address-only bus where writes carry no data.
package rtc_pkg;
    localparam int BUS_AW = 3;
    localparam int SNAP_W = 24;

    localparam logic [BUS_AW-1:0] ADR_SEC_LO  = 3'd0;
    localparam logic [BUS_AW-1:0] ADR_SEC_MID = 3'd1;
    localparam logic [BUS_AW-1:0] ADR_SEC_HI  = 3'd2;
    localparam logic [BUS_AW-1:0] ADR_CLK_CLR = 3'd3;
    localparam logic [BUS_AW-1:0] ADR_WD_KICK = 3'd4;

    typedef struct packed {
        logic rd_lo;
        logic rd_mid;
        logic rd_hi;
        logic clk_clr;
        logic wd_kick;
    } bus_strobe_t;
endpackage

// File: rtl/rtc_prescaler.sv
// Divides the low-frequency tick enable down to a one-per-second strobe.
// Assumes tick_en is one clock wide. A clear restarts the division and
// suppresses the strobe in that cycle.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr,
    output logic sec_stb
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    // Advance the divider on each tick and wrap after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            div_q <= '0;
        else if (tick_en)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    assign sec_stb = tick_en && !clr && (div_q == LAST);

    p_div_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
    p_div_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb |=> div_q == '0);
endmodule

// File: rtl/rtc_sec_counter.sv
// Saturating elapsed-seconds counter.
// Assumes sec_stb comes from the prescaler and clr has priority over it.
module rtc_sec_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sec_stb,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // Count seconds and hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (sec_stb && count != TOP)
            count <= count + 1'b1;
    end

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb && !clr && count != TOP |=> count == CNT_W'($past(count) + 1'b1));
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count == TOP && !clr |=> count == TOP);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/rtc_wdog.sv
// Watchdog that counts ticks and raises a one-cycle reset request on expiry.
// Assumes kick is already blocked upstream during power-down. A kick or a
// disable clears the count, and power-down freezes it.
module rtc_wdog #(
    parameter int WDOG_TICKS = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic kick,
    input  logic wd_off,
    input  logic pwr_down,
    output logic rst_req
);
    localparam int WW = (WDOG_TICKS > 1) ? $clog2(WDOG_TICKS) : 1;
    localparam logic [WW-1:0] LAST = WW'(WDOG_TICKS - 1);

    logic [WW-1:0] wd_q;

    // Count ticks toward expiry and pulse the request when it is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q    <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (kick || wd_off)
                wd_q <= '0;
            else if (tick_en && !pwr_down) begin
                if (wd_q == LAST) begin
                    wd_q    <= '0;
                    rst_req <= 1'b1;
                end else begin
                    wd_q <= wd_q + 1'b1;
                end
            end
        end
    end

    p_one_cycle_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_kick_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wd_q == '0 && !rst_req);
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> wd_q == '0 && !rst_req);
    p_pd_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down && !kick && !wd_off |=> $stable(wd_q));
endmodule

// File: rtl/rtc_regs.sv
// Register access: decodes the address-only bus, keeps the read snapshot and
// drives registered read data. Assumes one-cycle accesses; power-down blocks
// every access.
module rtc_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_down,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [SNAP_W-1:0] sec_count,
    output logic [7:0]        bus_rdata,
    output logic              clk_clr,
    output logic              wd_kick
);
    bus_strobe_t      stb;
    logic [SNAP_W-1:0] snap_q;

    // Decode accesses that are allowed outside power-down.
    always_comb begin
        stb         = '0;
        stb.rd_lo   = bus_sel && !pwr_down && !bus_wr && bus_addr == ADR_SEC_LO;
        stb.rd_mid  = bus_sel && !pwr_down && !bus_wr && bus_addr == ADR_SEC_MID;
        stb.rd_hi   = bus_sel && !pwr_down && !bus_wr && bus_addr == ADR_SEC_HI;
        stb.clk_clr = bus_sel && !pwr_down &&  bus_wr && bus_addr == ADR_CLK_CLR;
        stb.wd_kick = bus_sel && !pwr_down &&  bus_wr && bus_addr == ADR_WD_KICK;
    end

    assign clk_clr = stb.clk_clr;
    assign wd_kick = stb.wd_kick;

    // Capture the snapshot on a low-byte read and register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q    <= '0;
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            if (stb.rd_lo) begin
                snap_q    <= sec_count;
                bus_rdata <= sec_count[7:0];
            end else if (stb.rd_mid)
                bus_rdata <= snap_q[15:8];
            else if (stb.rd_hi)
                bus_rdata <= snap_q[23:16];
            else
                bus_rdata <= '0;
        end
    end

    p_lo_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb.rd_lo |=> snap_q == $past(sec_count));
    p_pd_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && pwr_down |=> bus_rdata == '0 && $stable(snap_q));
    p_pd_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !clk_clr && !wd_kick);
endmodule

// File: rtl/rtc_wdog_top.sv
// Elapsed-seconds clock with watchdog. It ties the prescaler, the saturating
// counter, the register access and the watchdog together. Assumes tick_en
// is a one-clock-wide 32.768 kHz enable and CNT_W is at most 24.
module rtc_wdog_top
    import rtc_pkg::*;
#(
    parameter int PRESCALE   = 32768,
    parameter int CNT_W      = 24,
    parameter int WDOG_TICKS = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pwr_down,
    input  logic              wdog_dis,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic [7:0]        bus_rdata,
    output logic              sys_rst_req
);
    logic             sec_stb;
    logic             clk_clr;
    logic             wd_kick;
    logic [CNT_W-1:0] sec_cnt;
    logic [SNAP_W-1:0] sec_wide;

    assign sec_wide = SNAP_W'(sec_cnt);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(clk_clr), .sec_stb(sec_stb)
    );

    rtc_sec_counter #(.CNT_W(CNT_W)) u_secs (
        .clk(clk), .rst_n(rst_n), .clr(clk_clr), .sec_stb(sec_stb), .count(sec_cnt)
    );

    rtc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .sec_count(sec_wide),
        .bus_rdata(bus_rdata), .clk_clr(clk_clr), .wd_kick(wd_kick)
    );

    rtc_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(wd_kick),
        .wd_off(wdog_dis), .pwr_down(pwr_down), .rst_req(sys_rst_req)
    );
endmodule

// File: tb/rtc_wdog_top_tb_top.sv
`timescale 1ns/1ps
module rtc_wdog_top_tb_top;
    localparam int P    = 4;
    localparam int CW   = 10;
    localparam int WT   = 40;
    localparam int MAXS = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic pwr_down = 1'b0;
    logic wdog_dis = 1'b1;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_rdata;
    logic sys_rst_req;

    int total = 0;
    int bad = 0;
    int tick_acc = 0;
    int pulses = 0;
    bit done = 1'b0;
    logic rd_q = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    rtc_wdog_top #(.PRESCALE(P), .CNT_W(CW), .WDOG_TICKS(WT)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_down(pwr_down),
        .wdog_dis(wdog_dis), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_secs();
        return (tick_acc / P > MAXS) ? MAXS : tick_acc / P;
    endfunction

    // Remember which cycles carried a read, and count reset pulses.
    always @(posedge clk) begin
        rd_q <= bus_sel && !bus_wr;
        if (sys_rst_req) pulses++;
    end

    // Monitor: pop the expected read data and compare it.
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                chk("read without expectation", int'(bus_rdata), -1);
            end else begin
                chk(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
            end
        end
    end

    task automatic do_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
            tick_acc++;
        end
    endtask

    task automatic do_read(input logic [2:0] a, input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk) begin bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; end
        @(negedge clk) bus_sel = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a);
        @(negedge clk) begin bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; end
        @(negedge clk) begin bus_sel = 1'b0; bus_wr = 1'b0; end
        if (a == 3'd3 && !pwr_down) tick_acc = 0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R11: reset state
        chk("R11 sys_rst_req after reset", int'(sys_rst_req), 0);
        do_read(3'd0, 0, "R11 low byte after reset");
        do_read(3'd1, 0, "R11 mid byte after reset");
        do_read(3'd2, 0, "R11 high byte after reset");
        do_read(3'd6, 0, "R12 unmapped read");
        // R1/R2: prescaling and increments
        do_tick(P - 1);
        do_read(3'd0, exp_secs(), "R1 no strobe before prescale");
        do_tick(1);
        do_read(3'd0, 1, "R2 one second");
        do_tick(2 * P);
        do_read(3'd0, 3, "R2 three seconds");
        // R6: clear resets prescaler and count
        do_tick(P - 1);
        do_write(3'd3);
        do_tick(P - 1);
        do_read(3'd0, 0, "R6 prescaler cleared");
        do_tick(1);
        do_read(3'd0, 1, "R6 count restarts");
        // R4: snapshot on low-byte read
        do_write(3'd3);
        do_tick(255 * P);
        do_read(3'd0, 255, "R4 low byte 255");
        do_tick(P);
        do_read(3'd1, 0, "R4 mid from snapshot");
        do_read(3'd2, 0, "R4 high from snapshot");
        do_read(3'd0, 0, "R4 low byte after carry");
        do_read(3'd1, 1, "R4 mid after new snapshot");
        // R3: saturation
        do_tick(800 * P);
        do_read(3'd0, 255, "R3 saturated low");
        do_read(3'd1, MAXS >> 8, "R3 saturated mid");
        do_tick(2 * P);
        do_read(3'd0, 255, "R3 hold low");
        do_read(3'd1, MAXS >> 8, "R3 hold mid");
        // R10/R9: power-down access blocking, clock keeps running
        do_write(3'd3);
        do_read(3'd1, MAXS >> 8, "R6 snapshot kept by clear");
        do_tick(2 * P);
        pwr_down = 1'b1;
        do_read(3'd0, 0, "R10 read blocked");
        do_write(3'd3);
        do_tick(P);
        pwr_down = 1'b0;
        do_read(3'd1, MAXS >> 8, "R10 latch untouched");
        do_read(3'd0, 3, "R9 counted in power-down, R10 clear ignored");
        // R5: watchdog expiry and restart
        wdog_dis = 1'b0;
        do_write(3'd4);
        p0 = pulses;
        do_tick(WT - 1);
        settle();
        chk("R5 no pulse before limit", pulses - p0, 0);
        do_tick(1);
        settle();
        chk("R5 pulse at limit", pulses - p0, 1);
        chk("R5 pulse single cycle", int'(sys_rst_req), 0);
        do_tick(WT);
        settle();
        chk("R5 pulse restarts count", pulses - p0, 2);
        // R7: kick in the same cycle as the expiring tick
        p0 = pulses;
        do_tick(WT - 1);
        @(negedge clk) begin tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; end
        @(negedge clk) begin tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; end
        tick_acc++;
        settle();
        chk("R7 kick wins same cycle", pulses - p0, 0);
        do_tick(WT - 1);
        settle();
        chk("R7 count restarted by kick", pulses - p0, 0);
        do_tick(1);
        settle();
        chk("R7 pulse after full window", pulses - p0, 1);
        // R8: disable
        wdog_dis = 1'b1;
        p0 = pulses;
        do_tick(WT + 5);
        settle();
        chk("R8 disabled no pulse", pulses - p0, 0);
        wdog_dis = 1'b0;
        do_tick(WT - 1);
        settle();
        chk("R8 count held at zero", pulses - p0, 0);
        do_tick(1);
        settle();
        chk("R8 pulse after release", pulses - p0, 1);
        // R9/R10: watchdog frozen and kick ignored in power-down
        do_write(3'd4);
        p0 = pulses;
        do_tick(WT - 2);
        pwr_down = 1'b1;
        do_tick(10);
        do_write(3'd4);
        settle();
        chk("R9 frozen in power-down", pulses - p0, 0);
        pwr_down = 1'b0;
        do_tick(1);
        settle();
        chk("R9 count kept", pulses - p0, 0);
        do_tick(1);
        settle();
        chk("R10 kick ignored in power-down", pulses - p0, 1);
        // R11: system reset clears the watchdog and the clock
        p0 = pulses;
        do_tick(WT - 1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tick_acc = 0;
        do_tick(1);
        settle();
        chk("R11 watchdog cleared by reset", pulses - p0, 0);
        do_tick(WT - 1);
        settle();
        chk("R11 full window after reset", pulses - p0, 1);
        do_read(3'd0, exp_secs(), "R11 seconds after reset");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule